// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a serial flash device and enforces its write-protection rules. Upstream command decoding hands it single-cycle strobes: set the write-enable latch, clear it, write a new status byte, and read the status byte. The internal array engine supplies a busy level and start and finish strobes for program and erase operations. An active-low write-protect pin is also an input.

The block drives the live status byte and a per-cycle acceptance flag for program and erase starts. A status read returns a captured copy of the byte one cycle later as a valid-qualified output. That path has no ready signal. The consumer must take the byte in the cycle `rd_valid` is high, and a later read simply overwrites it. The protection bits behave as non-volatile: they are registers that preset to their power-on values on reset. Address-range decoding and the serial shifter sit outside this block.

Top module: `flash_sr_ctrl`

## Requirements
- R1: After reset the status byte is 0x1C, meaning the three block-protect bits are 1 and all other bits are 0. `rd_valid` is 0 after reset.
- R2: The status byte has a fixed layout. Bit 0 is busy and follows `eng_busy` in the same cycle. Bit 1 is the write-enable latch. Bits 4:2 are the block-protect level. Bit 5 is the top/bottom select. Bit 6 always reads 0. Bit 7 is the protection lock.
- R3: `cmd_wren` sets the latch on the next edge when `eng_busy` is 0. While `eng_busy` is 1, `cmd_wren` is ignored.
- R4: `cmd_wrdi` clears the latch on the next edge when `eng_busy` is 0. While `eng_busy` is 1, `cmd_wrdi` is ignored.
- R5: `op_accept` is high in exactly the cycles where `op_start` is high, the latch is 1 and `eng_busy` is 0.
- R6: `op_done` clears the latch on the next edge. If `cmd_wren` arrives in the same cycle as `op_done`, the clear wins.
- R7: A status write is accepted when all four of these hold: the latch is 1, `eng_busy` is 0, `wp_n` is 1 and the lock is 0. In that case, data bits 4:2, 5 and 7 are loaded into the same status bit positions.
- R8: A status write made while the lock is 1 and `wp_n` is 1 leaves bits 4:2 and bit 5 unchanged, but it loads the lock bit from data bit 7.
- R9: A status write made while `wp_n` is 0 leaves bits 4:2, 5 and 7 unchanged.
- R10: A status write made while the latch is 0, or while `eng_busy` is 1, changes no protection bit. Any status write made while `eng_busy` is 0 clears the latch, whether or not the write was accepted.
- R11: `cmd_rdsr` is honoured even while busy. It raises `rd_valid` for one cycle on the next edge, and `rd_data` holds the status byte as it was in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrdi | input | 1 | Clear write-enable latch strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Status write data byte |
| cmd_rdsr | input | 1 | Status read strobe |
| op_start | input | 1 | Program or erase start request |
| op_done | input | 1 | Program or erase completion strobe |
| eng_busy | input | 1 | Array engine busy level |
| wp_n | input | 1 | Write-protect pin, active low |
| op_accept | output | 1 | Program or erase start accepted this cycle |
| status | output | 8 | Live status byte |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Captured status byte |

## Verification
Two of this block's functions can land in the same cycle. The first pair is a completion strobe and a latch-set command: both target the latch at once, and the clear must win. The second is a status write arriving while the write-protect pin or the lock is asserted: the protection bits must hold, and the latch must still clear. Seeded random stimulus draws every strobe independently, so these collisions occur many times. Directed sequences also force each collision explicitly. A bench reference model predicts the status byte every cycle, and each sampled output is compared against that prediction.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int SR_W   = 8;
  localparam int BP_W   = 3;
  localparam int B_BUSY = 0;
  localparam int B_WEL  = 1;
  localparam int B_BP0  = 2;
  localparam int B_TB   = B_BP0 + BP_W;
  localparam int B_RSV  = B_TB + 1;
  localparam int B_LOCK = B_RSV + 1;

  typedef struct packed {
    logic            lock;
    logic            tb;
    logic [BP_W-1:0] bp;
  } prot_t;

  localparam prot_t PROT_POR = '{lock: 1'b0, tb: 1'b0, bp: {BP_W{1'b1}}};
endpackage

// File: rtl/sr_wel_ctl.sv
module sr_wel_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic wren,
  input  logic wrdi,
  input  logic wrsr,
  input  logic op_done,
  output logic wel
);
  logic clr, set;

  always_comb begin
    clr = op_done | (~busy & (wrdi | wrsr));
    set = wren & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wel <= 1'b0;
    else if (clr) wel <= 1'b0;
    else if (set) wel <= 1'b1;
  end

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !wel);
  p_busy_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel) |=> !wel);
  p_wrsr_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr && !busy) |=> !wel);
endmodule

// File: rtl/sr_prot_regs.sv
module sr_prot_regs
  import flash_sr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wel,
  input  logic          busy,
  input  logic          wp_n,
  input  logic [SR_W-1:0] wdata,
  output prot_t         prot
);
  logic  take;
  prot_t nxt;

  always_comb begin
    take = wr_req & wel & ~busy & wp_n;
    nxt  = prot;
    if (take) begin
      nxt.lock = wdata[B_LOCK];
      if (!prot.lock) begin
        nxt.tb = wdata[B_TB];
        nxt.bp = wdata[B_BP0 +: BP_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot <= PROT_POR;
    else        prot <= nxt;
  end

  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prot.lock |=> ($stable(prot.bp) && $stable(prot.tb)));
  p_pin_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(prot));
  p_no_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel || busy) |=> $stable(prot));
endmodule

// File: rtl/sr_rd_port.sv
module sr_rd_port
  import flash_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_req,
  input  logic [SR_W-1:0] cur,
  output logic            rd_valid,
  output logic [SR_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= cur;
    end
  end

  p_read_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_data == $past(cur)));
endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wren,
  input  logic            cmd_wrdi,
  input  logic            cmd_wrsr,
  input  logic [SR_W-1:0] wrsr_data,
  input  logic            cmd_rdsr,
  input  logic            op_start,
  input  logic            op_done,
  input  logic            eng_busy,
  input  logic            wp_n,
  output logic            op_accept,
  output logic [SR_W-1:0] status,
  output logic            rd_valid,
  output logic [SR_W-1:0] rd_data
);
  logic  wel;
  prot_t prot;

  sr_wel_ctl u_wel (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .wren(cmd_wren),
    .wrdi(cmd_wrdi), .wrsr(cmd_wrsr), .op_done(op_done), .wel(wel)
  );

  sr_prot_regs u_prot (
    .clk(clk), .rst_n(rst_n), .wr_req(cmd_wrsr), .wel(wel), .busy(eng_busy),
    .wp_n(wp_n), .wdata(wrsr_data), .prot(prot)
  );

  always_comb begin
    status              = '0;
    status[B_BUSY]      = eng_busy;
    status[B_WEL]       = wel;
    status[B_BP0 +: BP_W] = prot.bp;
    status[B_TB]        = prot.tb;
    status[B_RSV]       = 1'b0;
    status[B_LOCK]      = prot.lock;
    op_accept           = op_start & wel & ~eng_busy;
  end

  sr_rd_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(cmd_rdsr), .cur(status),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  p_accept_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> (status[B_WEL] && !status[B_BUSY]));
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrsr |=> !status[B_RSV]);
endmodule

// File: tb/tb_flash_sr_ctrl.sv
module tb_flash_sr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_rdsr = 0;
  logic op_start = 0, op_done = 0, eng_busy = 0, wp_n = 1;
  logic [7:0] wrsr_data = 0;
  logic op_accept, rd_valid;
  logic [7:0] status, rd_data;

  int n_run = 0, n_fail = 0;

  logic m_wel = 0, m_tb = 0, m_lock = 0, m_rdv = 0;
  logic [2:0] m_bp = 3'b111;
  logic [7:0] m_rdd = 0;

  always #10 clk = ~clk;

  flash_sr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_rdsr(cmd_rdsr),
    .op_start(op_start), .op_done(op_done), .eng_busy(eng_busy), .wp_n(wp_n),
    .op_accept(op_accept), .status(status), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_status();
    return {m_lock, 1'b0, m_tb, m_bp, m_wel, eng_busy};
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic wren, input logic wrdi, input logic wrsr,
                       input logic [7:0] d, input logic rdsr, input logic st,
                       input logic dn, input logic bsy, input logic wp);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; wrsr_data = d;
    cmd_rdsr = rdsr; op_start = st; op_done = dn; eng_busy = bsy; wp_n = wp;
  endtask

  task automatic step(input string tag);
    logic n_wel, n_tb, n_lock;
    logic [2:0] n_bp;
    #1;
    chk({tag, " status"}, {1'b0, status}, {1'b0, exp_status()});
    chk("R5 op_accept", {8'h0, op_accept}, {8'h0, op_start & m_wel & ~eng_busy});
    chk("R11 read", {rd_valid, rd_valid ? rd_data : 8'h0}, {m_rdv, m_rdv ? m_rdd : 8'h0});
    n_wel = m_wel; n_tb = m_tb; n_lock = m_lock; n_bp = m_bp;
    if (op_done || (!eng_busy && (cmd_wrdi || cmd_wrsr))) n_wel = 1'b0;
    else if (cmd_wren && !eng_busy) n_wel = 1'b1;
    if (cmd_wrsr && m_wel && !eng_busy && wp_n) begin
      n_lock = wrsr_data[7];
      if (!m_lock) begin n_tb = wrsr_data[5]; n_bp = wrsr_data[4:2]; end
    end
    m_rdv = cmd_rdsr;
    if (cmd_rdsr) m_rdd = exp_status();
    @(negedge clk);
    m_wel = n_wel; m_tb = n_tb; m_lock = n_lock; m_bp = n_bp;
  endtask

  task automatic idle(input string tag);
    drive(0, 0, 0, 8'h00, 0, 0, 0, 0, 1);
    step(tag);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset status", {1'b0, status}, 9'h01C);
    chk("R1 reset rd_valid", {8'h0, rd_valid}, 9'h0);
    idle("R1");
    // R3: set latch while busy is ignored, then while idle it takes
    drive(1, 0, 0, 0, 0, 0, 0, 1, 1); step("R3 busy wren");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3 wren");
    drive(0, 1, 0, 0, 0, 0, 0, 1, 1); step("R4 busy wrdi");
    drive(0, 1, 0, 0, 0, 0, 0, 0, 1); step("R4 wrdi");
    idle("R4");
    // R5 + R6: accepted start, then done colliding with wren
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1); step("R5 accept");
    drive(1, 0, 0, 0, 1, 0, 1, 0, 1); step("R6 done vs wren");
    idle("R6");
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1); step("R5 reject");
    // R7: accepted write, bit 6 written as 1 reads 0
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3");
    drive(0, 0, 1, 8'hF4, 0, 0, 0, 0, 1); step("R7 write");
    idle("R7 R2");
    // R8: locked, bp/tb hold, lock cleared
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3");
    drive(0, 0, 1, 8'h08, 0, 0, 0, 0, 1); step("R8 locked");
    idle("R8");
    // R9: pin low blocks everything, latch still clears
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3");
    drive(0, 0, 1, 8'hBC, 1, 0, 0, 0, 0); step("R9 pin low");
    idle("R9");
    // R10: no latch, and busy
    drive(0, 0, 1, 8'h80, 0, 0, 0, 0, 1); step("R10 no latch");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 1); step("R3");
    drive(0, 0, 1, 8'h80, 1, 0, 0, 1, 1); step("R10 R11 busy");
    idle("R10");
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 5) == 0, ($urandom % 9) == 0, ($urandom % 6) == 0,
            8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
            ($urandom % 8) == 0, ($urandom % 4) == 0, ($urandom % 5) != 0);
      step("R2 R7 R8 R9 R10 random");
    end
    idle("R2");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule